// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash that follows the common unlock-sequence command protocol. A client hands it one request at a time. The request is to program one word, erase a sector, erase a block, or erase the whole array. The sequencer emits the matching unlock and command writes on a simple synchronous memory port. It then polls the target location and waits for the status bit to stop toggling.

The device can finish at any moment relative to a status read. For that reason, once toggling stops the sequencer waits for a settle interval. It then reads the location twice more. The result is accepted only if both reads equal the expected content: the requested word after a program, or all ones after an erase. A down-counter bounds the polling time and then times the settle interval. Timeouts and the settle interval are parameters counted in clock cycles.

The memory port is synchronous. Each cycle with `mem_req_o` high is one bus access. For a read, the data arrives on `mem_rdata_i` during the following cycle.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A program request (op code 0) drives exactly four writes, in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address.
- R2: Every erase drives exactly six writes, in this order: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then the final opcode. For a sector erase (op code 1), the final write is 30h to the request address.
- R3: For a block erase (op code 2), the final write is 50h to the request address. For a chip erase (op code 3), the final write is 10h to 5555h.
- R4: After the last command write, the block reads the request address in pairs. Polling stops when bit 6 is equal in both reads of a pair.
- R5: After polling stops, at least T_SETTLE idle cycles pass before the first verify read.
- R6: Two verify reads follow. If both equal the expected value (the request data for a program, all ones for an erase), `done_o` pulses and `err_code_o` is 0.
- R7: If either verify read differs from the expected value, `err_o` pulses with `err_code_o` = 2.
- R8: If toggling has not stopped within the op's timeout (T_PROG for a program, T_ERASE for a sector or block, T_CHIP for a chip), `err_o` pulses with `err_code_o` = 1.
- R9: A request is taken only while `busy_o` is low. A request presented while busy causes no bus traffic and no later operation.
- R10: `busy_o` rises in the cycle after acceptance. It stays high until the single cycle in which `done_o` or `err_o` pulses; in that cycle `busy_o` is low. Reset leaves all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr_i | input | AW | Word, sector or block address |
| req_data_i | input | DW | Word to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 2 | 0 none, 1 timeout, 2 verify mismatch |
| mem_req_o | output | 1 | Bus access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after the read |

## Verification
The assertions check the handshake on every cycle. A result pulse never coincides with busy, and success and failure never occur together. The error code agrees with the pulse type. No bus access happens while idle, an idle request always raises busy, and the timer saturates at zero. The write ordering, the opcodes, the toggle-based completion, the settle gap, and the timeout and verify-failure paths depend on how the device responds. Only the bench scenarios, driven against a behavioural device model, can show these.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_VERIFY  = 2'd2
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_P1, S_P2, S_PC, S_SET, S_V1, S_V2, S_VC
  } state_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
endpackage

// File: rtl/fsq_cmd_gen.sv
module fsq_cmd_gen import flash_seq_pkg::*; #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  op_e           op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [DW-1:0] tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_B);

  logic is_prog;
  assign is_prog = (op_i == OP_PROG);
  assign last_o  = is_prog ? (step_i == 3'd3) : (step_i == 3'd5);

  always_comb begin
    addr_o = ADDR_A;
    data_o = DW'(8'hAA);
    unique case (step_i)
      3'd0: ;
      3'd1: begin addr_o = ADDR_B; data_o = DW'(8'h55); end
      3'd2: data_o = is_prog ? DW'(8'hA0) : DW'(8'h80);
      3'd3: if (is_prog) begin addr_o = tgt_addr_i; data_o = tgt_data_i; end
      3'd4: begin addr_o = ADDR_B; data_o = DW'(8'h55); end
      default: begin
        // final erase opcode; chip erase stays on the unlock address
        if (op_i == OP_CHIP) data_o = DW'(8'h10);
        else begin
          addr_o = tgt_addr_i;
          data_o = (op_i == OP_SECT) ? DW'(8'h30) : DW'(8'h50);
        end
      end
    endcase
  end
endmodule

// File: rtl/fsq_timer.sv
module fsq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl import flash_seq_pkg::*; #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int T_PROG   = 3200,
  parameter int T_ERASE  = 3200000,
  parameter int T_CHIP   = 12800000,
  parameter int T_SETTLE = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_code_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int T_A = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
  localparam int T_B = (T_A > T_CHIP) ? T_A : T_CHIP;
  localparam int T_M = (T_B > T_SETTLE) ? T_B : T_SETTLE;
  localparam int CW  = $clog2(T_M + 1);

  state_e        state_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd1_q, expect_w;
  logic [2:0]    step_q;
  logic          busy_q, done_q, err_q;
  err_e          code_q;

  logic [AW-1:0] gen_addr;
  logic [DW-1:0] gen_data;
  logic          gen_last, stable_w;
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0] tmr_val;

  fsq_cmd_gen #(.AW(AW), .DW(DW)) i_cmd_gen (
    .op_i(op_q), .step_i(step_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .addr_o(gen_addr), .data_o(gen_data), .last_o(gen_last)
  );

  fsq_timer #(.CW(CW)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  assign expect_w = (op_q == OP_PROG) ? data_q : '1;
  assign stable_w = (mem_rdata_i[6] == rd1_q[6]);

  // one counter: poll timeout first, then settle interval
  always_comb begin
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_CMD: if (gen_last) begin
        tmr_load = 1'b1;
        unique case (op_q)
          OP_PROG: tmr_val = CW'(T_PROG);
          OP_CHIP: tmr_val = CW'(T_CHIP);
          default: tmr_val = CW'(T_ERASE);
        endcase
      end
      S_P1, S_P2, S_SET: tmr_dec = 1'b1;
      S_PC: if (stable_w) begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_SETTLE);
      end else tmr_dec = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      rd1_q   <= '0;
      step_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(req_op_i);
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          step_q  <= '0;
          busy_q  <= 1'b1;
          code_q  <= ERR_NONE;
          state_q <= S_CMD;
        end
        S_CMD: begin
          if (gen_last) state_q <= S_P1;
          else          step_q  <= step_q + 3'd1;
        end
        S_P1: begin
          if (tmr_zero) begin
            state_q <= S_IDLE;
            busy_q  <= 1'b0;
            err_q   <= 1'b1;
            code_q  <= ERR_TIMEOUT;
          end else state_q <= S_P2;
        end
        S_P2: begin
          rd1_q   <= mem_rdata_i;
          state_q <= S_PC;
        end
        S_PC:  state_q <= stable_w ? S_SET : S_P1;
        S_SET: if (tmr_zero) state_q <= S_V1;
        S_V1:  state_q <= S_V2;
        S_V2: begin
          rd1_q   <= mem_rdata_i;
          state_q <= S_VC;
        end
        S_VC: begin
          state_q <= S_IDLE;
          busy_q  <= 1'b0;
          if (rd1_q == expect_w && mem_rdata_i == expect_w) done_q <= 1'b1;
          else begin
            err_q  <= 1'b1;
            code_q <= ERR_VERIFY;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = state_q inside {S_CMD, S_P1, S_P2, S_V1, S_V2};
  assign mem_we_o    = (state_q == S_CMD);
  assign mem_addr_o  = mem_we_o ? gen_addr : addr_q;
  assign mem_wdata_o = mem_we_o ? gen_data : '0;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;

  a_r10_result_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  a_r10_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r9_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  a_r8_err_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != ERR_NONE));
  a_r6_ok_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_code_o == ERR_NONE));
  a_r5_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_V1) |-> tmr_zero);
endmodule

// File: tb/test_flash_seq_ctrl.sv
module test_flash_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int T_PROG = 40;
  localparam int T_ERASE = 120;
  localparam int T_CHIP = 200;
  localparam int T_SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          busy, done, err;
  logic [1:0]    err_code;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_ctrl #(.AW(AW), .DW(DW), .T_PROG(T_PROG), .T_ERASE(T_ERASE),
                   .T_CHIP(T_CHIP), .T_SETTLE(T_SETTLE)) i_flash_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(err_code), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // behavioural device model
  logic [15:0] arr [0:63];
  logic [AW-1:0] la [0:15];
  logic [15:0] ld [0:15];
  int rd_t [0:63];
  int nlog, nrd, cyc, dev_busy;
  bit tog, hang, corrupt;
  int busy_len = 12;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) arr[i] = 16'h0000;
      nlog = 0; nrd = 0; cyc = 0; dev_busy = 0; tog = 0;
      mem_rdata <= '0;
    end else begin
      cyc++;
      if (dev_busy > 0 && !hang) dev_busy--;
      if (req_valid && !busy) begin nlog = 0; nrd = 0; end
      if (mem_req && mem_we) begin
        if (nlog < 16) begin la[nlog] = mem_addr; ld[nlog] = mem_wdata; end
        nlog++;
        if (dev_busy == 0) begin
          if (nlog == 4 && ld[2][7:0] == 8'hA0) begin
            arr[mem_addr[5:0]] = corrupt ? (mem_wdata ^ 16'h0001) : mem_wdata;
            dev_busy = busy_len;
          end else if (nlog == 6) begin
            for (int i = 0; i < 64; i++) arr[i] = 16'hFFFF;
            dev_busy = busy_len;
          end
        end
      end
      if (mem_req && !mem_we) begin
        if (nrd < 64) rd_t[nrd] = cyc;
        nrd++;
        if (dev_busy > 0) begin
          tog = !tog;
          mem_rdata <= tog ? 16'h0040 : 16'h0000;
        end else mem_rdata <= arr[mem_addr[5:0]];
      end
    end
  end

  int total = 0, bad = 0;
  bit got_done, got_err, busy_bad;
  logic [1:0] got_code;
  int elapsed;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [15:0] d, input int poke_at);
    int t0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    t0 = cyc;
    got_done = 0; got_err = 0; busy_bad = 0; got_code = '0;
    for (int i = 0; i < 3000; i++) begin
      if (i == poke_at) begin
        req_valid = 1'b1; req_op = 2'd3; req_addr = 18'h9; req_data = 16'hDEAD;
      end
      if (i == poke_at + 2) req_valid = 1'b0;
      if (done || err) begin
        got_done = done; got_err = err; got_code = err_code;
        if (busy) busy_bad = 1;
        break;
      end
      if (!busy) busy_bad = 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    elapsed = cyc - t0;
    check(got_done || got_err, "R10", "operation finished", 0, 1);
    check(!busy_bad, "R10", "busy held until result", busy_bad, 0);
  endtask

  task automatic chk_wr(input int idx, input logic [14:0] a, input logic [7:0] d,
                        input string req);
    check(la[idx][14:0] == a, req, $sformatf("write %0d addr", idx), la[idx][14:0], a);
    check(ld[idx][7:0] == d, req, $sformatf("write %0d data", idx), ld[idx][7:0], d);
  endtask

  task automatic t_reset;
    check(!busy && !done && !err && !mem_req, "R10", "reset outputs",
          {busy, done, err, mem_req}, 0);
  endtask

  task automatic t_program(input logic [5:0] a, input logic [15:0] d);
    busy_len = 12;
    run_op(2'd0, AW'(a), d, -1);
    check(nlog == 4, "R1", "program write count", nlog, 4);
    chk_wr(0, 15'h5555, 8'hAA, "R1");
    chk_wr(1, 15'h2AAA, 8'h55, "R1");
    chk_wr(2, 15'h5555, 8'hA0, "R1");
    check(la[3] == AW'(a) && ld[3] == d, "R1", "program target write", ld[3], d);
    check(got_done && got_code == 2'd0, "R6", "program done code", got_code, 0);
    check(arr[a] == d, "R6", "stored word", arr[a], d);
    check(nrd > 4, "R4", "toggle poll reads", nrd, 5);
    if (nrd >= 3)
      check(rd_t[nrd-2] - rd_t[nrd-3] >= T_SETTLE + 1, "R5", "settle gap",
            rd_t[nrd-2] - rd_t[nrd-3], T_SETTLE + 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_erase(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [7:0] code, input logic [14:0] fa, input string req);
    busy_len = 20;
    run_op(op, a, 16'h0, -1);
    check(nlog == 6, "R2", "erase write count", nlog, 6);
    chk_wr(0, 15'h5555, 8'hAA, "R2");
    chk_wr(1, 15'h2AAA, 8'h55, "R2");
    chk_wr(2, 15'h5555, 8'h80, "R2");
    chk_wr(3, 15'h5555, 8'hAA, "R2");
    chk_wr(4, 15'h2AAA, 8'h55, "R2");
    chk_wr(5, fa, code, req);
    check(got_done && got_code == 2'd0, "R6", "erase done code", got_code, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_timeout;
    hang = 1; busy_len = 30;
    run_op(2'd0, 18'h7, 16'h5A5A, -1);
    check(got_err && got_code == 2'd1, "R8", "timeout code", got_code, 1);
    check(elapsed >= T_PROG, "R8", "timeout not early", elapsed, T_PROG);
    hang = 0;
    repeat (busy_len + 5) @(negedge clk);
  endtask

  task automatic t_verify_fail;
    corrupt = 1; busy_len = 8;
    run_op(2'd0, 18'h2, 16'h1111, -1);
    check(got_err && got_code == 2'd2, "R7", "verify error code", got_code, 2);
    corrupt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignore;
    busy_len = 10;
    run_op(2'd0, 18'h3, 16'h0040, 3);
    check(nlog == 4, "R9", "no extra writes while busy", nlog, 4);
    check(got_done && arr[3] == 16'h0040, "R9", "word after ignored request", arr[3], 16'h0040);
    repeat (20) begin
      @(negedge clk);
      check(!busy && !mem_req, "R9", "no late operation", {busy, mem_req}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hang = 0; corrupt = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_program(6'h05, 16'h1234);
    t_program(6'h06, 16'hBFBF);
    t_erase(2'd1, 18'h2_1800, 8'h30, 15'h1800, "R2");
    t_erase(2'd2, 18'h3_8000, 8'h50, 15'h0000, "R3");
    t_erase(2'd3, 18'h0_0007, 8'h10, 15'h5555, "R3");
    t_timeout();
    t_verify_fail();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule